// File: doc/BRIEF.md
# Sequential Particle Stream Memory Controller

This block moves a fixed-size set of particle records between a particle-filter pipeline stage and a burst-oriented external memory. The user side has no address. A stage reads or writes particles strictly in index order, and the controller generates every memory address itself. Each algorithm stage begins with a one-cycle start pulse. The pulse latches the stage direction and the target memory space, and it returns the particle pointer to particle 0.

Memory is split into three equal spaces: a main space for particles in their routine form and two alternate spaces used during a correction pass. One particle occupies one 128-bit beat, and four beats form one memory burst. On a read stage the controller issues burst reads ahead of demand and parks the returned beats in a local FIFO, so the consumer normally finds data already waiting. On a write stage it packs incoming particles into bursts and sends each burst as soon as it is full. A final partial burst is flushed with a beat mask. The particle count is a parameter.

Top module: `particle_stream_ctrl`

## Requirements
- R1: After reset, and until the first start pulse, `stage_done`, `rd_valid`, `wr_ready` and `mem_req_valid` are all 0.
- R2: A start pulse latches `stage_dir` (1 = write, 0 = read) and `region_sel`, and it resets the particle pointer. The first particle of every stage, including a restarted one, is particle 0 at the base of the selected space.
- R3: With SPAN = ceil(N/4)*4 beats, space k (k = 0, 1, 2 from `region_sel`) starts at beat address k*SPAN, and `region_sel` = 3 selects space 0. Burst j of a stage is requested at base + 4*j, so every request address is a multiple of 4 and lies below 3*SPAN.
- R4: On a read stage, particles are delivered on `rd_data` in index order. Particle i is beat (i mod 4) of the read burst at base + 4*(i/4), and it is taken when `rd_valid` and `rd_ready` are both 1.
- R5: Read requests are issued only while FIFO occupancy plus beats still owed by memory plus 4 does not exceed the FIFO depth. With a stalled consumer and the default depth of 8, exactly 2 bursts are requested and `rd_valid` is 1 before the first pop.
- R6: A read stage issues exactly ceil(N/4) burst reads and delivers exactly N particles. `rd_valid` is 0 whenever the FIFO is empty. A write stage accepts exactly N particles, and `wr_ready` is 0 after that.
- R7: On a write stage each full burst carries mask 4'b1111, with particle 4*j+b in bits [b*128 +: 128] of `mem_req_wdata`.
- R8: The last write burst of a stage carries a mask with the low (N mod 4) bits set when N is not a multiple of 4. Beats outside the mask leave memory unchanged.
- R9: `stage_done` rises after the N-th particle is popped on a read stage or after the burst holding the N-th particle is accepted on a write stage. It stays 1 until the next start pulse, which clears it.
- R10: A memory request held with `mem_req_ready` low keeps its valid, direction, address, data and mask unchanged in the next cycle.
- R11: Beats of the final read burst whose particle index is N or more are discarded and never appear on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stage_start | input | 1 | One-cycle pulse at the start of a stage |
| stage_dir | input | 1 | Stage direction latched at start: 1 write, 0 read |
| region_sel | input | 2 | Memory space latched at start (3 maps to space 0) |
| rd_valid | output | 1 | A particle is available on rd_data |
| rd_ready | input | 1 | Consumer takes the particle this cycle |
| rd_data | output | BEAT_W | Next particle in index order |
| wr_valid | input | 1 | Producer offers a particle |
| wr_ready | output | 1 | Controller accepts the offered particle |
| wr_data | input | BEAT_W | Particle to store |
| stage_done | output | 1 | All N particles of the stage delivered or committed |
| mem_req_valid | output | 1 | Burst request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Request is a burst write |
| mem_req_addr | output | ADDR_W | Beat address of the burst's first beat |
| mem_req_wdata | output | BURST_LEN*BEAT_W | Write beats, beat b in bits [b*BEAT_W +: BEAT_W] |
| mem_req_mask | output | BURST_LEN | Per-beat write enable (all ones on reads) |
| mem_rsp_valid | input | 1 | One read beat returns |
| mem_rsp_data | input | BEAT_W | Returned read beat |

## Verification
The assertions assume that memory returns exactly four read beats per accepted read request, in request order and at most one per cycle. They also assume that a start pulse never arrives while read beats are still owed or while a write burst is waiting for `mem_req_ready`. The stimulus respects this: after `stage_done` and after any aborted read, it waits idle cycles so that the memory model's fixed-latency queue drains before the next pulse. It also never raises a start while a request is outstanding. Under these conditions the FIFO budget and request-stability properties hold throughout, including the stalled-ready phases of the write tests.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        SPACE_MAIN  = 2'd0,
        SPACE_ALT_A = 2'd1,
        SPACE_ALT_B = 2'd2
    } space_e;

    typedef struct packed {
        dir_e   dir;
        space_e space;
    } stage_cfg_t;

    localparam int NUM_SPACES = 3;

    function automatic int bursts_for(input int n, input int blen);
        return (n + blen - 1) / blen;
    endfunction

    function automatic int space_span(input int n, input int blen);
        return bursts_for(n, blen) * blen;
    endfunction

    function automatic space_e decode_space(input logic [1:0] sel);
        space_e s;
        case (sel)
            2'd1:    s = SPACE_ALT_A;
            2'd2:    s = SPACE_ALT_B;
            default: s = SPACE_MAIN;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pmc_sync_fifo.sv
module pmc_sync_fifo #(
    parameter int WIDTH = 128,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear,
    input  logic                       push,
    input  logic [WIDTH-1:0]           push_data,
    input  logic                       pop,
    output logic [WIDTH-1:0]           pop_data,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] storage [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= next_ptr(wr_ptr);
            if (pop)  rd_ptr <= next_ptr(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) storage[wr_ptr] <= push_data;
    end

    assign pop_data = storage[rd_ptr];

endmodule

// File: rtl/pmc_burst_addr.sv
module pmc_burst_addr
    import pmc_pkg::*;
#(
    parameter int N_PARTICLES = 10,
    parameter int BURST_LEN   = 4,
    parameter int ADDR_W      = 16
) (
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic                                         start,
    input  space_e                                       space,
    input  logic                                         advance,
    output logic [$clog2(bursts_for(N_PARTICLES, BURST_LEN)+1)-1:0] burst_idx,
    output logic                                         all_issued,
    output logic [ADDR_W-1:0]                            addr
);
    localparam int NBURST = bursts_for(N_PARTICLES, BURST_LEN);
    localparam int SPAN   = space_span(N_PARTICLES, BURST_LEN);
    localparam int IDX_W  = $clog2(NBURST + 1);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] offset;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            burst_idx <= '0;
        end else if (advance && !all_issued) begin
            burst_idx <= burst_idx + IDX_W'(1);
        end
    end

    always_comb begin
        all_issued = (int'(burst_idx) >= NBURST);
        base       = ADDR_W'(int'(space) * SPAN);
        offset     = ADDR_W'(int'(burst_idx) * BURST_LEN);
        addr       = base + offset;
    end

endmodule

// File: rtl/pmc_read_prefetch.sv
module pmc_read_prefetch
    import pmc_pkg::*;
#(
    parameter int N_PARTICLES = 10,
    parameter int BURST_LEN   = 4,
    parameter int BEAT_W      = 128,
    parameter int DEPTH       = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic                       active,
    input  logic                       all_issued,
    output logic                       req_valid,
    input  logic                       req_ready,
    input  logic                       rsp_valid,
    input  logic [BEAT_W-1:0]          rsp_data,
    output logic                       rd_valid,
    input  logic                       rd_ready,
    output logic [BEAT_W-1:0]          rd_data,
    output logic [$clog2(DEPTH+1)-1:0] fifo_count,
    output logic [$clog2(DEPTH+1)-1:0] outstanding,
    output logic                       done
);
    localparam int NBURST = bursts_for(N_PARTICLES, BURST_LEN);
    localparam int OCC_W  = $clog2(DEPTH + 1);
    localparam int RP_W   = $clog2(NBURST * BURST_LEN + 1);
    localparam int PC_W   = $clog2(N_PARTICLES + 1);

    logic [RP_W-1:0]  rsp_pidx;
    logic [PC_W-1:0]  delivered;
    logic             budget_ok;
    logic             req_fire;
    logic             keep_beat;
    logic             push;
    logic             pop;
    logic [OCC_W-1:0] add_beats;
    logic [OCC_W-1:0] sub_beats;

    always_comb begin
        budget_ok = (int'(fifo_count) + int'(outstanding) + BURST_LEN) <= DEPTH;
        req_valid = active && !all_issued && budget_ok;
        req_fire  = req_valid && req_ready;
        keep_beat = int'(rsp_pidx) < N_PARTICLES;
        push      = active && rsp_valid && keep_beat;
        rd_valid  = active && (fifo_count != '0);
        pop       = rd_valid && rd_ready;
        add_beats = req_fire  ? OCC_W'(BURST_LEN) : '0;
        sub_beats = rsp_valid ? OCC_W'(1) : '0;
        done      = active && (int'(delivered) == N_PARTICLES);
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            outstanding <= '0;
            rsp_pidx    <= '0;
            delivered   <= '0;
        end else begin
            outstanding <= outstanding + add_beats - sub_beats;
            if (rsp_valid) rsp_pidx  <= rsp_pidx + RP_W'(1);
            if (pop)       delivered <= delivered + PC_W'(1);
        end
    end

    pmc_sync_fifo #(
        .WIDTH (BEAT_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .clear     (start),
        .push      (push),
        .push_data (rsp_data),
        .pop       (pop),
        .pop_data  (rd_data),
        .count     (fifo_count)
    );

endmodule

// File: rtl/pmc_write_packer.sv
module pmc_write_packer
    import pmc_pkg::*;
#(
    parameter int N_PARTICLES = 10,
    parameter int BURST_LEN   = 4,
    parameter int BEAT_W      = 128
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic                          active,
    input  logic                          wr_valid,
    output logic                          wr_ready,
    input  logic [BEAT_W-1:0]             wr_data,
    output logic                          req_valid,
    input  logic                          req_ready,
    output logic [BURST_LEN*BEAT_W-1:0]   req_wdata,
    output logic [BURST_LEN-1:0]          req_mask,
    output logic                          done
);
    localparam int FILL_W = $clog2(BURST_LEN + 1);
    localparam int SLOT_W = $clog2(BURST_LEN);
    localparam int PC_W   = $clog2(N_PARTICLES + 1);

    logic [BEAT_W-1:0] beat_buf [BURST_LEN];
    logic [FILL_W-1:0] fill;
    logic [PC_W-1:0]   accepted;
    logic [PC_W-1:0]   committed;
    logic              pending;
    logic              accept;
    logic              burst_closes;

    always_comb begin
        wr_ready     = active && !pending && (int'(accepted) != N_PARTICLES);
        accept       = wr_valid && wr_ready;
        burst_closes = (int'(fill) + 1 == BURST_LEN) ||
                       (int'(accepted) + 1 == N_PARTICLES);
        req_valid    = pending;
        done         = active && (int'(committed) == N_PARTICLES);
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            fill      <= '0;
            accepted  <= '0;
            committed <= '0;
            pending   <= 1'b0;
        end else if (accept) begin
            fill     <= fill + FILL_W'(1);
            accepted <= accepted + PC_W'(1);
            if (burst_closes) pending <= 1'b1;
        end else if (pending && req_ready) begin
            pending   <= 1'b0;
            fill      <= '0;
            committed <= committed + PC_W'(fill);
        end
    end

    always_ff @(posedge clk) begin
        if (accept) beat_buf[SLOT_W'(fill)] <= wr_data;
    end

    for (genvar g = 0; g < BURST_LEN; g++) begin : g_lane
        always_comb begin
            req_mask[g]                    = pending && (g < int'(fill));
            req_wdata[g*BEAT_W +: BEAT_W] = req_mask[g] ? beat_buf[g] : '0;
        end
    end

endmodule

// File: rtl/particle_stream_ctrl.sv
module particle_stream_ctrl
    import pmc_pkg::*;
#(
    parameter int N_PARTICLES = 10,
    parameter int BEAT_W      = 128,
    parameter int BURST_LEN   = 4,
    parameter int FIFO_DEPTH  = 8,
    parameter int ADDR_W      = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        stage_start,
    input  logic                        stage_dir,
    input  logic [1:0]                  region_sel,
    output logic                        rd_valid,
    input  logic                        rd_ready,
    output logic [BEAT_W-1:0]           rd_data,
    input  logic                        wr_valid,
    output logic                        wr_ready,
    input  logic [BEAT_W-1:0]           wr_data,
    output logic                        stage_done,
    output logic                        mem_req_valid,
    input  logic                        mem_req_ready,
    output logic                        mem_req_write,
    output logic [ADDR_W-1:0]           mem_req_addr,
    output logic [BURST_LEN*BEAT_W-1:0] mem_req_wdata,
    output logic [BURST_LEN-1:0]        mem_req_mask,
    input  logic                        mem_rsp_valid,
    input  logic [BEAT_W-1:0]           mem_rsp_data
);
    localparam int NBURST = bursts_for(N_PARTICLES, BURST_LEN);
    localparam int IDX_W  = $clog2(NBURST + 1);
    localparam int OCC_W  = $clog2(FIFO_DEPTH + 1);

    stage_cfg_t                  cfg;
    logic                        stage_active;
    logic                        rd_active;
    logic                        wr_active;
    logic                        rd_req_valid;
    logic                        wr_req_valid;
    logic                        req_fire;
    logic                        all_issued;
    logic [IDX_W-1:0]            burst_idx;
    logic [OCC_W-1:0]            fifo_count;
    logic [OCC_W-1:0]            rd_outstanding;
    logic                        rd_done;
    logic                        wr_done;
    logic [BURST_LEN*BEAT_W-1:0] wr_wdata;
    logic [BURST_LEN-1:0]        wr_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_active <= 1'b0;
            cfg          <= '{dir: DIR_READ, space: SPACE_MAIN};
        end else if (stage_start) begin
            stage_active <= 1'b1;
            cfg.dir      <= dir_e'(stage_dir);
            cfg.space    <= decode_space(region_sel);
        end
    end

    always_comb begin
        rd_active     = stage_active && (cfg.dir == DIR_READ);
        wr_active     = stage_active && (cfg.dir == DIR_WRITE);
        mem_req_valid = rd_req_valid || wr_req_valid;
        mem_req_write = wr_active;
        mem_req_wdata = wr_wdata;
        mem_req_mask  = wr_active ? wr_mask : '1;
        req_fire      = mem_req_valid && mem_req_ready;
        stage_done    = rd_done || wr_done;
    end

    pmc_burst_addr #(
        .N_PARTICLES (N_PARTICLES),
        .BURST_LEN   (BURST_LEN),
        .ADDR_W      (ADDR_W)
    ) u_addr (
        .clk        (clk),
        .rst        (rst),
        .start      (stage_start),
        .space      (cfg.space),
        .advance    (req_fire),
        .burst_idx  (burst_idx),
        .all_issued (all_issued),
        .addr       (mem_req_addr)
    );

    pmc_read_prefetch #(
        .N_PARTICLES (N_PARTICLES),
        .BURST_LEN   (BURST_LEN),
        .BEAT_W      (BEAT_W),
        .DEPTH       (FIFO_DEPTH)
    ) u_rd (
        .clk         (clk),
        .rst         (rst),
        .start       (stage_start),
        .active      (rd_active),
        .all_issued  (all_issued),
        .req_valid   (rd_req_valid),
        .req_ready   (mem_req_ready),
        .rsp_valid   (mem_rsp_valid),
        .rsp_data    (mem_rsp_data),
        .rd_valid    (rd_valid),
        .rd_ready    (rd_ready),
        .rd_data     (rd_data),
        .fifo_count  (fifo_count),
        .outstanding (rd_outstanding),
        .done        (rd_done)
    );

    pmc_write_packer #(
        .N_PARTICLES (N_PARTICLES),
        .BURST_LEN   (BURST_LEN),
        .BEAT_W      (BEAT_W)
    ) u_wr (
        .clk       (clk),
        .rst       (rst),
        .start     (stage_start),
        .active    (wr_active),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .wr_data   (wr_data),
        .req_valid (wr_req_valid),
        .req_ready (mem_req_ready),
        .req_wdata (wr_wdata),
        .req_mask  (wr_mask),
        .done      (wr_done)
    );

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
    parameter int N_PARTICLES = 10,
    parameter int BEAT_W      = 128,
    parameter int BURST_LEN   = 4,
    parameter int FIFO_DEPTH  = 8,
    parameter int ADDR_W      = 16
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        start,
    input logic                        done,
    input logic                        rd_valid,
    input logic                        mreq_valid,
    input logic                        mreq_ready,
    input logic                        mreq_write,
    input logic [ADDR_W-1:0]           mreq_addr,
    input logic [BURST_LEN*BEAT_W-1:0] mreq_wdata,
    input logic [BURST_LEN-1:0]        mreq_mask,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_count,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] outstanding
);
    localparam int SPAN = ((N_PARTICLES + BURST_LEN - 1) / BURST_LEN) * BURST_LEN;

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && !mreq_valid && !rd_valid));

    assert_addr_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        mreq_valid |-> ((int'(mreq_addr) % BURST_LEN) == 0 && int'(mreq_addr) < 3 * SPAN));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (int'(fifo_count) + int'(outstanding)) <= FIFO_DEPTH);

    assert_valid_needs_data_R6: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (fifo_count != '0));

    assert_mask_contiguous_R8: assert property (@(posedge clk) disable iff (rst)
        (mreq_valid && mreq_write) |->
            (mreq_mask != '0 && ((mreq_mask & (mreq_mask + 1'b1)) == '0)));

    assert_done_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    assert_req_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (mreq_valid && !mreq_ready && !start) |=>
            (mreq_valid && $stable(mreq_addr) && $stable(mreq_write) &&
             $stable(mreq_wdata) && $stable(mreq_mask)));

endmodule

bind particle_stream_ctrl pmc_checker #(
    .N_PARTICLES (N_PARTICLES),
    .BEAT_W      (BEAT_W),
    .BURST_LEN   (BURST_LEN),
    .FIFO_DEPTH  (FIFO_DEPTH),
    .ADDR_W      (ADDR_W)
) u_pmc_checker (
    .clk         (clk),
    .rst         (rst),
    .start       (stage_start),
    .done        (stage_done),
    .rd_valid    (rd_valid),
    .mreq_valid  (mem_req_valid),
    .mreq_ready  (mem_req_ready),
    .mreq_write  (mem_req_write),
    .mreq_addr   (mem_req_addr),
    .mreq_wdata  (mem_req_wdata),
    .mreq_mask   (mem_req_mask),
    .fifo_count  (fifo_count),
    .outstanding (rd_outstanding)
);

// File: tb/tb_particle_stream_ctrl.sv
module tb_particle_stream_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 10;
    localparam int BEAT_W     = 128;
    localparam int BL         = 4;
    localparam int DEPTH      = 8;
    localparam int ADDR_W     = 16;
    localparam int NB         = (N + BL - 1) / BL;
    localparam int SPAN       = NB * BL;
    localparam int MEM_BEATS  = 3 * SPAN;
    localparam int RSP_LAT    = 3;
    localparam logic [BEAT_W-1:0] SENTINEL = {4{32'hDEAD_BEEF}};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stage_start = 1'b0;
    logic stage_dir = 1'b0;
    logic [1:0] region_sel = 2'd0;
    logic rd_valid;
    logic rd_ready = 1'b0;
    logic [BEAT_W-1:0] rd_data;
    logic wr_valid = 1'b0;
    logic wr_ready;
    logic [BEAT_W-1:0] wr_data = '0;
    logic stage_done;
    logic mem_req_valid;
    logic mem_req_ready = 1'b1;
    logic mem_req_write;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [BL*BEAT_W-1:0] mem_req_wdata;
    logic [BL-1:0] mem_req_mask;
    logic mem_rsp_valid = 1'b0;
    logic [BEAT_W-1:0] mem_rsp_data = '0;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    particle_stream_ctrl #(
        .N_PARTICLES (N),
        .BEAT_W      (BEAT_W),
        .BURST_LEN   (BL),
        .FIFO_DEPTH  (DEPTH),
        .ADDR_W      (ADDR_W)
    ) dut (
        .clk           (clk),
        .rst           (rst),
        .stage_start   (stage_start),
        .stage_dir     (stage_dir),
        .region_sel    (region_sel),
        .rd_valid      (rd_valid),
        .rd_ready      (rd_ready),
        .rd_data       (rd_data),
        .wr_valid      (wr_valid),
        .wr_ready      (wr_ready),
        .wr_data       (wr_data),
        .stage_done    (stage_done),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_req_mask  (mem_req_mask),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    // memory model: decides and drives at the falling edge
    logic [BEAT_W-1:0] mem [MEM_BEATS];
    bit   mem_init_done = 0;
    bit   stall_ready = 0;
    int   cyc = 0;
    int   read_bursts = 0;
    int   rq_addr[$];
    int   rq_due[$];
    int   wlog_addr[$];
    int   wlog_mask[$];

    always @(negedge clk) begin
        if (!mem_init_done) begin
            for (int i = 0; i < MEM_BEATS; i++) mem[i] = SENTINEL;
            mem_init_done = 1;
        end
        cyc++;
        mem_req_ready = stall_ready ? (cyc % 3 == 0) : 1'b1;
        if (!rst && mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                for (int b = 0; b < BL; b++)
                    if (mem_req_mask[b]) mem[int'(mem_req_addr) + b] = mem_req_wdata[b*BEAT_W +: BEAT_W];
                wlog_addr.push_back(int'(mem_req_addr));
                wlog_mask.push_back(int'(mem_req_mask));
            end else begin
                read_bursts++;
                for (int b = 0; b < BL; b++) begin
                    rq_addr.push_back(int'(mem_req_addr) + b);
                    rq_due.push_back(cyc + RSP_LAT + b);
                end
            end
        end
        mem_rsp_valid = 1'b0;
        if (rq_addr.size() > 0 && rq_due[0] <= cyc) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem[rq_addr[0]];
            void'(rq_addr.pop_front());
            void'(rq_due.pop_front());
        end
    end

    function automatic logic [BEAT_W-1:0] pdata(input int space, input int seed, input int i);
        return {16'hA5A5, 16'(space), 32'(seed), 32'(i), 32'(32'hC0DE_0000 + i)};
    endfunction

    task automatic check(input string tag, input logic [BEAT_W-1:0] act, input logic [BEAT_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    task automatic pulse_start(input logic dir, input logic [1:0] sel);
        @(negedge clk);
        stage_dir   = dir;
        region_sel  = sel;
        stage_start = 1'b1;
        @(negedge clk);
        stage_start = 1'b0;
    endtask

    // consume `count` particles starting at index first_idx, checking order
    task automatic consume(input int space, input int seed, input int first_idx,
                           input int count, input bit slow);
        int idx = first_idx;
        int to  = 0;
        while (idx < first_idx + count && to < 2000) begin
            @(negedge clk);
            to++;
            rd_ready = slow ? (to % 4 != 0) : 1'b1;
            if (rd_ready && rd_valid) begin
                check($sformatf("R4 particle %0d", idx), rd_data, pdata(space, seed, idx));
                idx++;
            end
        end
        check("R4 consume completed", 128'(idx), 128'(first_idx + count));
        @(negedge clk);
        rd_ready = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 done after reset", 128'(stage_done), 128'(0));
        check("R1 rd_valid after reset", 128'(rd_valid), 128'(0));
        check("R1 wr_ready after reset", 128'(wr_ready), 128'(0));
        check("R1 mem_req_valid after reset", 128'(mem_req_valid), 128'(0));
    endtask

    task automatic t_write_stage(input int space, input int seed, input bit stall);
        int idx = 0;
        int to  = 0;
        int base = space * SPAN;
        wlog_addr.delete();
        wlog_mask.delete();
        stall_ready = stall;
        pulse_start(1'b1, 2'(space));
        check("R9 done cleared by start", 128'(stage_done), 128'(0));
        while (idx < N && to < 2000) begin
            @(negedge clk);
            to++;
            wr_valid = 1'b1;
            wr_data  = pdata(space, seed, idx);
            if (wr_ready) idx++;
        end
        @(negedge clk);
        wr_valid = 1'b0;
        to = 0;
        while (!stage_done && to < 200) begin
            @(negedge clk);
            to++;
        end
        check("R9 done after final write commit", 128'(stage_done), 128'(1));
        check("R6 wr_ready low after N accepted", 128'(wr_ready), 128'(0));
        check("R7 write burst count", 128'(wlog_addr.size()), 128'(NB));
        for (int k = 0; k < NB && k < wlog_addr.size(); k++) begin
            int exp_mask = (k == NB - 1 && (N % BL) != 0) ? ((1 << (N % BL)) - 1) : ((1 << BL) - 1);
            check($sformatf("R3 write burst %0d address", k), 128'(wlog_addr[k]), 128'(base + k * BL));
            check($sformatf("R8 write burst %0d mask", k), 128'(wlog_mask[k]), 128'(exp_mask));
        end
        for (int i = 0; i < SPAN; i++) begin
            if (i < N) check($sformatf("R7 stored particle %0d", i), mem[base + i], pdata(space, seed, i));
            else       check($sformatf("R8 unmasked beat %0d untouched", i), mem[base + i], SENTINEL);
        end
        stall_ready = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_read_stage(input logic [1:0] sel, input int space, input int seed, input bit slow);
        int extra = 0;
        read_bursts = 0;
        pulse_start(1'b0, sel);
        check("R9 done cleared by read start", 128'(stage_done), 128'(0));
        consume(space, seed, 0, N, slow);
        check("R9 done after N-th pop", 128'(stage_done), 128'(1));
        check("R6 read burst count", 128'(read_bursts), 128'(NB));
        rd_ready = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (rd_valid) extra++;
        end
        rd_ready = 1'b0;
        check("R11 no particle beyond N", 128'(extra), 128'(0));
        check("R9 done held", 128'(stage_done), 128'(1));
    endtask

    task automatic t_prefetch_window();
        read_bursts = 0;
        rd_ready = 1'b0;
        pulse_start(1'b0, 2'd1);
        repeat (30) @(negedge clk);
        check("R5 bursts issued with stalled consumer", 128'(read_bursts), 128'(DEPTH / BL));
        check("R5 data waiting before first pop", 128'(rd_valid), 128'(1));
        check("R9 done low mid-stage", 128'(stage_done), 128'(0));
        consume(1, 2, 0, N, 1'b1);
        check("R9 done after prefetch stage", 128'(stage_done), 128'(1));
        repeat (10) @(negedge clk);
    endtask

    task automatic t_restart();
        pulse_start(1'b0, 2'd1);
        consume(1, 2, 0, 3, 1'b0);
        repeat (20) @(negedge clk);
        pulse_start(1'b0, 2'd1);
        consume(1, 2, 0, N, 1'b0);
        check("R2 restarted stage completes", 128'(stage_done), 128'(1));
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        t_reset();
        t_write_stage(0, 1, 1'b0);
        t_write_stage(1, 2, 1'b1);   // stalled ready exercises R10
        t_write_stage(2, 3, 1'b0);
        t_read_stage(2'd2, 2, 3, 1'b0);
        t_read_stage(2'd0, 0, 1, 1'b1);
        t_read_stage(2'd3, 0, 1, 1'b0);  // R3: select 3 maps to main space
        t_prefetch_window();
        t_restart();
        finish_run();
    end

endmodule